// File: doc/BRIEF.md
# HDLC receive bit deframer

This block sits behind a bit-level demodulator. It takes one recovered bit per strobe and rebuilds the byte stream for a receive FIFO. Every incoming bit goes into an 8-bit history register. The block watches that history for three things: the opening flag, the abort pattern, and the zero that a transmitter inserts after five ones in a row.

A flag that is seen while the FIFO has room is forwarded as a byte, and reception starts. A run of seven ones stops reception. Once reception is running, the bits that are not stuffed zeros are assembled LSB first. Each completed byte is pushed to the FIFO.

Flags travel in-band in the output stream. A data byte that matches one of the three control codes therefore needs a marker in front of it. The block pushes an escape byte (0x1B) in the cycle after the eighth bit, and pushes the data byte itself one cycle later. The FIFO reports fullness through a flag. Any push attempted while that flag is high is dropped, and reception stops until the next flag arrives.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: After synchronous reset, no push occurs and reception is off, so data bits that arrive before any flag produce no output.
- R2: When the 8-bit history, with each new bit entering at bit 0, equals 0x7E and the FIFO is not full, the block pushes 0x7E and turns reception on. In either case it clears the partially assembled byte and the bit count.
- R3: A flag that completes while the FIFO is full is not pushed, and reception is turned off.
- R4: When the low seven history bits are all one (abort pattern 0x7F), reception is turned off and the bit causes no push.
- R5: While reception is off, bits produce no output other than through flag detection.
- R6: A zero bit whose history ends in the pattern 111110 (five ones, then the new zero) is a stuffed bit and is discarded.
- R7: Data bits are assembled LSB first. The completed byte is pushed in the cycle after the strobe of its eighth bit.
- R8: A completed byte equal to 0x7E, 0x7F or 0x1B causes a push of 0x1B in the cycle after its eighth bit, followed by a push of the byte itself in the next cycle.
- R9: A data or escape push attempted while the FIFO is full is dropped, and reception is turned off.
- R10: Bit strobes are at least two cycles apart, which leaves the cycle after an escape free for the escaped byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bitValid | input | 1 | Strobe marking a recovered bit |
| bitIn | input | 1 | Value of the recovered bit |
| fifoFull | input | 1 | Receive FIFO cannot accept a byte |
| pushValid | output | 1 | Byte push toward the FIFO |
| pushData | output | 8 | Byte being pushed |

## Verification
Flag, escape and plain data pushes appear one cycle after the edge that samples the strobe of the bit that completes them. An escaped byte appears one cycle after its escape. The bench drives inputs just after a rising edge and samples on the falling edge. Strobes are two cycles apart, so every push falls in its own sampling window and is compared, in order, against the scoreboard queue. After each scenario, a drain check confirms that no expected push went missing.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

  localparam int BYTE_W    = 8;
  localparam int IDX_W     = $clog2(BYTE_W);
  localparam int STUFF_RUN = 5;
  localparam int NUM_CTRL  = 3;

  localparam logic [BYTE_W-1:0] FLAG_CODE  = 8'h7E;
  localparam logic [BYTE_W-1:0] ABORT_CODE = 8'h7F;
  localparam logic [BYTE_W-1:0] ESC_CODE   = 8'h1B;

  localparam logic [BYTE_W-1:0] CTRL_CODES [NUM_CTRL] = '{FLAG_CODE, ABORT_CODE, ESC_CODE};

  // five ones followed by the newest bit at zero
  localparam logic [STUFF_RUN:0] STUFF_PAT = {{STUFF_RUN{1'b1}}, 1'b0};

  // datapath observations for the control
  typedef struct packed {
    logic flagHit;
    logic abortHit;
    logic stuffHit;
    logic lastBit;
    logic ctrlByte;
  } rx_status_t;

  // control strobes into the datapath
  typedef struct packed {
    logic shiftHist;
    logic clearAsm;
    logic takeBit;
    logic stashByte;
    logic emitFlag;
    logic emitEsc;
    logic emitNow;
    logic emitPend;
  } rx_strobe_t;

endpackage

// File: rtl/hdlc_rx_datapath.sv
module hdlc_rx_datapath
  import hdlc_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bitIn,
  input  rx_strobe_t        strobe,
  output rx_status_t        status,
  output logic              pushValid,
  output logic [BYTE_W-1:0] pushData
);

  logic [BYTE_W-1:0] hist;
  logic [BYTE_W-1:0] histNext;
  logic [BYTE_W-1:0] asmByte;
  logic [BYTE_W-1:0] asmFill;
  logic [BYTE_W-1:0] pendByte;
  logic [IDX_W-1:0]  bitIdx;
  logic              isCtrl;

  assign histNext = {hist[BYTE_W-2:0], bitIn};
  assign asmFill  = bitIn ? (asmByte | {1'b1, {(BYTE_W-1){1'b0}}}) : asmByte;

  always_comb begin
    isCtrl = 1'b0;
    for (int i = 0; i < NUM_CTRL; i++) begin
      if (asmFill == CTRL_CODES[i]) isCtrl = 1'b1;
    end
  end

  always_comb begin
    status.flagHit  = (histNext == FLAG_CODE);
    status.abortHit = ((histNext & ABORT_CODE) == ABORT_CODE);
    status.stuffHit = (histNext[STUFF_RUN:0] == STUFF_PAT);
    status.lastBit  = (bitIdx == IDX_W'(BYTE_W-1));
    status.ctrlByte = isCtrl;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist     <= '0;
      asmByte  <= '0;
      bitIdx   <= '0;
      pendByte <= '0;
    end else begin
      if (strobe.shiftHist) hist <= histNext;
      if (strobe.clearAsm) begin
        asmByte <= '0;
        bitIdx  <= '0;
      end else if (strobe.takeBit) begin
        if (status.lastBit) begin
          asmByte <= '0;
          bitIdx  <= '0;
        end else begin
          asmByte <= asmFill >> 1;
          bitIdx  <= bitIdx + IDX_W'(1);
        end
      end
      if (strobe.stashByte) pendByte <= asmFill;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pushValid <= 1'b0;
      pushData  <= '0;
    end else begin
      pushValid <= strobe.emitFlag | strobe.emitEsc | strobe.emitNow | strobe.emitPend;
      if (strobe.emitFlag)      pushData <= FLAG_CODE;
      else if (strobe.emitEsc)  pushData <= ESC_CODE;
      else if (strobe.emitNow)  pushData <= asmFill;
      else if (strobe.emitPend) pushData <= pendByte;
    end
  end

endmodule

// File: rtl/hdlc_rx_control.sv
module hdlc_rx_control
  import hdlc_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       bitValid,
  input  logic       fifoFull,
  input  rx_status_t status,
  output rx_strobe_t strobe
);

  logic rxOn;
  logic rxOnNext;
  logic pendValid;
  logic pendNext;

  always_comb begin
    strobe   = '0;
    rxOnNext = rxOn;
    pendNext = 1'b0;

    // second half of an escaped pair
    if (pendValid) begin
      if (!fifoFull) strobe.emitPend = 1'b1;
      else           rxOnNext        = 1'b0;
    end

    if (bitValid) begin
      strobe.shiftHist = 1'b1;
      if (status.flagHit) begin
        strobe.clearAsm = 1'b1;
        if (!fifoFull) begin
          strobe.emitFlag = 1'b1;
          rxOnNext        = 1'b1;
        end else begin
          rxOnNext = 1'b0;
        end
      end else if (status.abortHit) begin
        rxOnNext = 1'b0;
      end else if (rxOn && !status.stuffHit) begin
        strobe.takeBit = 1'b1;
        if (status.lastBit) begin
          if (status.ctrlByte) begin
            strobe.stashByte = 1'b1;
            pendNext         = 1'b1;
            if (!fifoFull) strobe.emitEsc = 1'b1;
            else           rxOnNext       = 1'b0;
          end else begin
            if (!fifoFull) strobe.emitNow = 1'b1;
            else           rxOnNext       = 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rxOn      <= 1'b0;
      pendValid <= 1'b0;
    end else begin
      rxOn      <= rxOnNext;
      pendValid <= pendNext;
    end
  end

endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
  import hdlc_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       bitValid,
  input  logic       bitIn,
  input  logic       fifoFull,
  output logic       pushValid,
  output logic [7:0] pushData
);

  rx_strobe_t strobe;
  rx_status_t status;

  hdlc_rx_control u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .bitValid (bitValid),
    .fifoFull (fifoFull),
    .status   (status),
    .strobe   (strobe)
  );

  hdlc_rx_datapath u_dp (
    .clk       (clk),
    .rst       (rst),
    .bitIn     (bitIn),
    .strobe    (strobe),
    .status    (status),
    .pushValid (pushValid),
    .pushData  (pushData)
  );

endmodule

// File: rtl/hdlc_rx_deframer_chk.sv
module hdlc_rx_deframer_chk
  import hdlc_rx_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       bitValid,
  input logic       bitIn,
  input logic       fifoFull,
  input logic       pushValid,
  input logic [7:0] pushData
);

  logic [2:0] onesRun;
  logic       escPhase;
  logic       escLead;
  logic       escLeadQ;
  logic       dataIsCtrl;

  assign escLead    = pushValid && (pushData == ESC_CODE) && !escPhase;
  assign dataIsCtrl = (pushData == FLAG_CODE) || (pushData == ABORT_CODE) || (pushData == ESC_CODE);

  always_ff @(posedge clk) begin
    if (rst) begin
      onesRun  <= '0;
      escPhase <= 1'b0;
      escLeadQ <= 1'b0;
    end else begin
      if (bitValid) begin
        if (!bitIn)               onesRun <= '0;
        else if (onesRun != 3'd7) onesRun <= onesRun + 3'd1;
      end
      if (pushValid) escPhase <= escLead;
      escLeadQ <= escLead;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !pushValid);

  assert_abort_silent_R4: assert property (@(posedge clk) disable iff (rst)
    (bitValid && bitIn && onesRun >= 3'd6) |=> !pushValid);

  assert_push_cause_R7: assert property (@(posedge clk) disable iff (rst)
    pushValid |-> ($past(bitValid) || escLeadQ));

  assert_escape_pair_R8: assert property (@(posedge clk) disable iff (rst)
    (escLead && !fifoFull) |=> (pushValid && dataIsCtrl));

  assert_no_push_when_full_R9: assert property (@(posedge clk) disable iff (rst)
    pushValid |-> !$past(fifoFull));

  assert_bit_spacing_R10: assert property (@(posedge clk) disable iff (rst)
    bitValid |=> !bitValid);

endmodule

bind hdlc_rx_deframer hdlc_rx_deframer_chk u_chk (.*);

// File: tb/sim_hdlc_rx_deframer.sv
module sim_hdlc_rx_deframer;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       bitValid;
  logic       bitIn;
  logic       fifoFull;
  logic       pushValid;
  logic [7:0] pushData;

  int         testsRun = 0;
  int         testsFailed = 0;
  int         onesTx = 0;
  string      curTag = "R1";
  logic [7:0] expQ[$];
  string      reqQ[$];
  logic [7:0] expByte;
  string      expTag;

  always #(CLK_PERIOD/2) clk = ~clk;

  hdlc_rx_deframer u0 (
    .clk       (clk),
    .rst       (rst),
    .bitValid  (bitValid),
    .bitIn     (bitIn),
    .fifoFull  (fifoFull),
    .pushValid (pushValid),
    .pushData  (pushData)
  );

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && pushValid) begin
      testsRun++;
      if (expQ.size() == 0) begin
        testsFailed++;
        $display("FAIL %s: unexpected push actual %h expected none", curTag, pushData);
      end else begin
        expByte = expQ.pop_front();
        expTag  = reqQ.pop_front();
        if (pushData !== expByte) begin
          testsFailed++;
          $display("FAIL %s: pushData actual %h expected %h", expTag, pushData, expByte);
        end
      end
    end
  end

  function automatic bit isCtrl(input logic [7:0] d);
    return (d == 8'h7E) || (d == 8'h7F) || (d == 8'h1B);
  endfunction

  task automatic expectByte(input logic [7:0] d, input string tag);
    expQ.push_back(d);
    reqQ.push_back(tag);
  endtask

  task automatic sendBit(input logic b);
    @(posedge clk);
    #1 bitValid = 1'b1;
    bitIn = b;
    @(posedge clk);
    #1 bitValid = 1'b0;
  endtask

  task automatic sendRaw(input logic b);
    sendBit(b);
    onesTx = 0;
  endtask

  task automatic sendFlag(input bit wantPush, input string tag);
    logic [7:0] f = 8'h7E;
    curTag = tag;
    if (wantPush) expectByte(8'h7E, tag);
    for (int i = 7; i >= 0; i--) sendBit(f[7-i]);
    onesTx = 0;
  endtask

  task automatic sendByte(input logic [7:0] d, input bit wantPush, input string tag);
    curTag = tag;
    if (wantPush) begin
      if (isCtrl(d)) expectByte(8'h1B, tag);
      expectByte(d, tag);
    end
    for (int i = 0; i < 8; i++) begin
      sendBit(d[i]);
      if (d[i]) begin
        onesTx++;
        if (onesTx == 5) begin
          sendBit(1'b0);
          onesTx = 0;
        end
      end else begin
        onesTx = 0;
      end
    end
  endtask

  task automatic drain(input string tag);
    repeat (4) @(posedge clk);
    @(negedge clk);
    testsRun++;
    if (expQ.size() != 0) begin
      testsFailed++;
      $display("FAIL %s: missing pushes actual 0 expected %0d", tag, expQ.size());
      expQ.delete();
      reqQ.delete();
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    rst = 1'b1;
    bitValid = 1'b0;
    bitIn = 1'b0;
    fifoFull = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    testsRun++;
    if (pushValid !== 1'b0) begin
      testsFailed++;
      $display("FAIL R1: pushValid after reset actual %b expected 0", pushValid);
    end

    // R1 / R5: data without a flag is ignored
    sendByte(8'h41, 0, "R1");
    sendByte(8'hFF, 0, "R5");
    drain("R5");

    // R2 R7 R6: plain frame with stuffed bytes
    sendFlag(1, "R2");
    sendByte(8'h41, 1, "R7");
    sendByte(8'hA5, 1, "R7");
    sendByte(8'hFF, 1, "R6");
    sendByte(8'h3E, 1, "R6");
    sendFlag(1, "R2");
    drain("R7");

    // R8: control-valued data bytes are escaped
    sendByte(8'h7E, 1, "R8");
    sendByte(8'h7F, 1, "R8");
    sendByte(8'h1B, 1, "R8");
    sendByte(8'h20, 1, "R8");
    sendFlag(1, "R8");
    drain("R8");

    // R4: abort stops reception until the next flag
    sendByte(8'h55, 1, "R4");
    for (int i = 0; i < 7; i++) sendRaw(1'b1);
    sendByte(8'h33, 0, "R4");
    drain("R4");
    sendFlag(1, "R4");
    sendByte(8'h66, 1, "R4");
    drain("R4");

    // R2: a flag clears a partial byte; 5 partial bits + 3 flag bits form C9
    sendRaw(1'b1); sendRaw(1'b0); sendRaw(1'b0); sendRaw(1'b1); sendRaw(1'b0);
    expectByte(8'hC9, "R2");
    sendFlag(1, "R2");
    sendByte(8'hA5, 1, "R2");
    sendFlag(1, "R2");
    drain("R2");

    // R3: flag while full is dropped and reception stays off
    fifoFull = 1'b1;
    sendFlag(0, "R3");
    fifoFull = 1'b0;
    sendByte(8'h41, 0, "R3");
    drain("R3");
    sendFlag(1, "R3");
    sendByte(8'h42, 1, "R3");
    drain("R3");

    // R9: data push while full disables reception
    fifoFull = 1'b1;
    sendByte(8'h41, 0, "R9");
    fifoFull = 1'b0;
    sendByte(8'h42, 0, "R9");
    drain("R9");
    sendFlag(1, "R9");

    // R9: escape and escaped byte while full
    fifoFull = 1'b1;
    sendByte(8'h7E, 0, "R9");
    @(posedge clk);
    #1 fifoFull = 1'b0;
    sendByte(8'h43, 0, "R9");
    drain("R9");
    sendFlag(1, "R9");
    sendByte(8'h1B, 1, "R9");
    sendFlag(1, "R9");
    drain("R9");

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule